// File: doc/BRIEF.md
# EDAC Configuration Register Port

This block sits on the control side of an error-correcting memory port. It watches the ordinary memory strobes and recognises a special access cycle: the chip is selected through both enables, the output enable and write enable are both inactive (high), and the error pin is held high from outside. Three address bits then pick the operation. One operation writes the EDAC control register. Its values come from address bits, not from the data bus. A second operation reads the register back. A third returns the scrub scheduler's address pointer on the data bus. The stored fields feed the scrub scheduler (strobe delay code, scrub disable) and the codec (bypass, single- or multiple-error flag mode).

The block is clocked and samples the port once per cycle. A state machine, `port_state_e`, has five states:
- `ST_IDLE`: no special cycle is active.
- `ST_CFG_WR`: a register write has been taken.
- `ST_CFG_RD`: the register is being read back.
- `ST_CNT_RD`: the scrub pointer is being read.
- `ST_RSVD`: a reserved combination was seen.

It has three transitions:
- enter: `ST_IDLE` goes to the state matching the decoded operation when a special cycle is seen.
- hold: the state stays while the same special cycle persists.
- leave: the state returns to `ST_IDLE` when the special cycle ends or its decoded operation changes.

A register write takes effect only on the enter transition, so a held write cycle writes once. The register resets to zero with `cfg_valid` low. The actual contents are meaningless until the first write.

Top module: `edac_cfg_port`

## Requirements
- R1: After reset the state is idle: `rd_drive` is 0, `rd_data` is 0, `cfg_valid` is 0, `scrub_ptr_clr` is 0, and all configuration fields are 0.
- R2: A cycle is special only when `ce_n`=0, `ce`=1, `oe_n`=1, `we_n`=1 and `err_pin`=1. Any other cycle changes no register and leaves `rd_drive` at 0 and `rd_data` at 0 from the next cycle on.
- R3: A special cycle with addr[10]=0 and addr[9]=0, entered from idle, stores the following one clock edge later and sets `cfg_valid`:
  - addr[7:4] into `dly_code`;
  - addr[8] into `edac_bypass`;
  - addr[11] into `scrub_disable`;
  - addr[12] into `single_err_mode`.
- R4: Holding a write cycle over further edges, even while its data address bits change, stores nothing more. The fields change only at an edge that also raises `scrub_ptr_clr`.
- R5: Each accepted register write raises `scrub_ptr_clr` for exactly one cycle, the same cycle in which the new fields appear. The scrub pointer is reset to all ones on this strobe.
- R6: A special cycle with addr[10]=0 and addr[9]=1 drives the register image from the next cycle on, with `rd_drive`=1:
  - `dly_code` at bits 7:4;
  - `edac_bypass` at bit 8;
  - `scrub_disable` at bit 11;
  - `single_err_mode` at bit 12;
  - every other bit 0.
- R7: A special cycle with addr[10]=1 and addr[7]=1 drives `scrub_ptr` on bits 18:0 and 0 on bits 31:19 from the next cycle on, with `rd_drive`=1.
- R8: A special cycle with addr[10]=1 and addr[7]=0 is reserved: `rd_drive` stays 0, `rd_data` stays 0, and no field changes.
- R9: `codec_enable` = `cfg_valid` AND NOT `edac_bypass`. `scrub_enable` = `codec_enable` AND NOT `scrub_disable`.
- R10: If the decoded operation changes while the special cycle is held, the port spends one cycle idle (`rd_drive`=0) before the new operation takes effect. A write reached this way is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| ce | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| err_pin | input | 1 | Level on the error pin, held high externally to key a special cycle |
| addr | input | 19 | Port address; selects the operation and carries write values |
| scrub_ptr | input | 19 | Current scrub address pointer from the scheduler |
| rd_data | output | 32 | Read-back value for the data bus |
| rd_drive | output | 1 | Data bus drive enable; 0 means high impedance |
| dly_code | output | 4 | Busy-to-scrub-strobe delay code |
| edac_bypass | output | 1 | 1 turns off correction and scrub |
| scrub_disable | output | 1 | 1 turns off scrub only |
| single_err_mode | output | 1 | 1 flags single-bit errors, 0 flags multi-bit errors |
| cfg_valid | output | 1 | Set by the first register write after reset |
| codec_enable | output | 1 | Correction active |
| scrub_enable | output | 1 | Scrub scheduling allowed |
| scrub_ptr_clr | output | 1 | One-cycle strobe that resets the scrub pointer to all ones |

## Verification
The checker watches several properties on every cycle:
- the bus is never driven unless the previous sample was a special cycle;
- the write strobe is a single-cycle pulse and always comes with `cfg_valid`;
- the fields never move without that strobe;
- unused read-back bits are zero for both read operations;
- scrub is never enabled without correction.

Some behaviours only the bench's scenarios can show:
- the exact values stored and read back;
- that a held write does not write again;
- that a reserved combination and a non-keyed cycle leave everything alone;
- the one idle cycle when the operation changes mid-cycle.

// File: rtl/edac_cfg_pkg.sv
package edac_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_WR,
        ST_CFG_RD,
        ST_CNT_RD,
        ST_RSVD
    } port_state_e;

    typedef enum logic [1:0] {
        OP_CFG_WR,
        OP_CFG_RD,
        OP_CNT_RD,
        OP_RSVD
    } special_op_e;

    function automatic port_state_e op_to_state(special_op_e op);
        port_state_e s;
        unique case (op)
            OP_CFG_WR: s = ST_CFG_WR;
            OP_CFG_RD: s = ST_CFG_RD;
            OP_CNT_RD: s = ST_CNT_RD;
            default:   s = ST_RSVD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/edac_op_decode.sv
module edac_op_decode
    import edac_cfg_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int RSEL_BIT = 9,
    parameter int GSEL_BIT = 10,
    parameter int CSEL_BIT = 7
) (
    input  logic              ce_n,
    input  logic              ce,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              err_pin,
    input  logic [ADDR_W-1:0] addr,
    output logic              special,
    output special_op_e       op
);

    always_comb begin
        special = !ce_n && ce && oe_n && we_n && err_pin;
        if (addr[GSEL_BIT]) begin
            op = addr[CSEL_BIT] ? OP_CNT_RD : OP_RSVD;
        end else begin
            op = addr[RSEL_BIT] ? OP_CFG_RD : OP_CFG_WR;
        end
    end

endmodule

// File: rtl/edac_cfg_store.sv
module edac_cfg_store #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 32,
    parameter int DLY_LSB  = 4,
    parameter int DLY_W    = 4,
    parameter int BYP_BIT  = 8,
    parameter int SDIS_BIT = 11,
    parameter int SBE_BIT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] addr,
    output logic [DLY_W-1:0]  dly_code,
    output logic              bypass,
    output logic              scrub_dis,
    output logic              sbe_mode,
    output logic              valid,
    output logic              clr_strobe,
    output logic [DATA_W-1:0] image
);

    localparam int DLY_MSB = DLY_LSB + DLY_W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_code   <= '0;
            bypass     <= 1'b0;
            scrub_dis  <= 1'b0;
            sbe_mode   <= 1'b0;
            valid      <= 1'b0;
            clr_strobe <= 1'b0;
        end else begin
            clr_strobe <= wr_fire;
            if (wr_fire) begin
                dly_code  <= addr[DLY_MSB:DLY_LSB];
                bypass    <= addr[BYP_BIT];
                scrub_dis <= addr[SDIS_BIT];
                sbe_mode  <= addr[SBE_BIT];
                valid     <= 1'b1;
            end
        end
    end

    always_comb begin
        image                   = '0;
        image[DLY_MSB:DLY_LSB]  = dly_code;
        image[BYP_BIT]          = bypass;
        image[SDIS_BIT]         = scrub_dis;
        image[SBE_BIT]          = sbe_mode;
    end

endmodule

// File: rtl/edac_cfg_port.sv
module edac_cfg_port
    import edac_cfg_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 19,
    parameter int DLY_LSB  = 4,
    parameter int DLY_W    = 4,
    parameter int CSEL_BIT = 7,
    parameter int BYP_BIT  = 8,
    parameter int RSEL_BIT = 9,
    parameter int GSEL_BIT = 10,
    parameter int SDIS_BIT = 11,
    parameter int SBE_BIT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              err_pin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  scrub_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic [DLY_W-1:0]  dly_code,
    output logic              edac_bypass,
    output logic              scrub_disable,
    output logic              single_err_mode,
    output logic              cfg_valid,
    output logic              codec_enable,
    output logic              scrub_enable,
    output logic              scrub_ptr_clr
);

    localparam int PAD_W = DATA_W - CNT_W;

    port_state_e state_q, state_d;
    special_op_e op;
    logic        special;
    logic        wr_fire;
    logic [DATA_W-1:0] cfg_image;

    edac_op_decode #(
        .ADDR_W  (ADDR_W),
        .RSEL_BIT(RSEL_BIT),
        .GSEL_BIT(GSEL_BIT),
        .CSEL_BIT(CSEL_BIT)
    ) u_dec (
        .ce_n   (ce_n),
        .ce     (ce),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .err_pin(err_pin),
        .addr   (addr),
        .special(special),
        .op     (op)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: enter / hold / leave
    always_comb begin
        state_d = state_q;
        wr_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (special) begin
                    state_d = op_to_state(op);
                    wr_fire = (op == OP_CFG_WR);
                end
            end
            ST_CFG_WR, ST_CFG_RD, ST_CNT_RD, ST_RSVD: begin
                if (!special || op_to_state(op) != state_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    edac_cfg_store #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DLY_LSB (DLY_LSB),
        .DLY_W   (DLY_W),
        .BYP_BIT (BYP_BIT),
        .SDIS_BIT(SDIS_BIT),
        .SBE_BIT (SBE_BIT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .addr      (addr),
        .dly_code  (dly_code),
        .bypass    (edac_bypass),
        .scrub_dis (scrub_disable),
        .sbe_mode  (single_err_mode),
        .valid     (cfg_valid),
        .clr_strobe(scrub_ptr_clr),
        .image     (cfg_image)
    );

    // Outputs by state
    always_comb begin
        rd_data  = '0;
        rd_drive = 1'b0;
        unique case (state_q)
            ST_CFG_RD: begin
                rd_data  = cfg_image;
                rd_drive = 1'b1;
            end
            ST_CNT_RD: begin
                rd_data  = {{PAD_W{1'b0}}, scrub_ptr};
                rd_drive = 1'b1;
            end
            default: begin
                rd_data  = '0;
                rd_drive = 1'b0;
            end
        endcase
    end

    assign codec_enable = cfg_valid && !edac_bypass;
    assign scrub_enable = codec_enable && !scrub_disable;

endmodule

// File: rtl/edac_cfg_port_chk.sv
module edac_cfg_port_chk #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 19,
    parameter int DLY_W    = 4,
    parameter int DLY_LSB  = 4,
    parameter int GSEL_BIT = 10,
    parameter int RSEL_BIT = 9,
    parameter int BYP_BIT  = 8,
    parameter int SBE_BIT  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              ce,
    input logic              oe_n,
    input logic              we_n,
    input logic              err_pin,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive,
    input logic [DLY_W-1:0]  dly_code,
    input logic              edac_bypass,
    input logic              scrub_disable,
    input logic              single_err_mode,
    input logic              cfg_valid,
    input logic              codec_enable,
    input logic              scrub_enable,
    input logic              scrub_ptr_clr
);

    logic keyed;
    assign keyed = !ce_n && ce && oe_n && we_n && err_pin;

    // R2
    drive_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(keyed));

    // R5
    clr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_ptr_clr |=> !scrub_ptr_clr);

    // R3
    clr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_ptr_clr |-> cfg_valid);

    // R4
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scrub_ptr_clr |-> ($stable(dly_code) && $stable(edac_bypass) &&
                            $stable(scrub_disable) && $stable(single_err_mode)));

    // R7
    cnt_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive && $past(addr[GSEL_BIT])) |-> (rd_data[DATA_W-1:CNT_W] == '0));

    // R6
    cfg_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive && !$past(addr[GSEL_BIT])) |->
            (rd_data[DLY_LSB-1:0] == '0 && rd_data[GSEL_BIT:RSEL_BIT] == '0 &&
             rd_data[DATA_W-1:SBE_BIT+1] == '0));

    // R9
    scrub_needs_codec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_enable |-> (codec_enable && cfg_valid && !edac_bypass));

    // R2
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

endmodule

bind edac_cfg_port edac_cfg_port_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .DLY_W   (DLY_W),
    .DLY_LSB (DLY_LSB),
    .GSEL_BIT(GSEL_BIT),
    .RSEL_BIT(RSEL_BIT),
    .BYP_BIT (BYP_BIT),
    .SBE_BIT (SBE_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ce_n           (ce_n),
    .ce             (ce),
    .oe_n           (oe_n),
    .we_n           (we_n),
    .err_pin        (err_pin),
    .addr           (addr),
    .rd_data        (rd_data),
    .rd_drive       (rd_drive),
    .dly_code       (dly_code),
    .edac_bypass    (edac_bypass),
    .scrub_disable  (scrub_disable),
    .single_err_mode(single_err_mode),
    .cfg_valid      (cfg_valid),
    .codec_enable   (codec_enable),
    .scrub_enable   (scrub_enable),
    .scrub_ptr_clr  (scrub_ptr_clr)
);

// File: tb/edac_cfg_port_bench.sv
module edac_cfg_port_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, ce = 1'b0, oe_n = 1'b1, we_n = 1'b1, err_pin = 1'b0;
    logic [18:0] addr = '0;
    logic [18:0] scrub_ptr = '0;
    logic [31:0] rd_data;
    logic        rd_drive;
    logic [3:0]  dly_code;
    logic        edac_bypass, scrub_disable, single_err_mode, cfg_valid;
    logic        codec_enable, scrub_enable, scrub_ptr_clr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model: 0 idle, 1 write, 2 cfg read, 3 pointer read, 4 reserved
    int       m_state = 0;
    bit       m_chg = 0, m_clr = 0, m_valid = 0;
    bit [3:0] m_dly = 0;
    bit       m_byp = 0, m_sdis = 0, m_sbe = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edac_cfg_port u_edac_cfg_port (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .we_n(we_n),
        .err_pin(err_pin), .addr(addr), .scrub_ptr(scrub_ptr),
        .rd_data(rd_data), .rd_drive(rd_drive), .dly_code(dly_code),
        .edac_bypass(edac_bypass), .scrub_disable(scrub_disable),
        .single_err_mode(single_err_mode), .cfg_valid(cfg_valid),
        .codec_enable(codec_enable), .scrub_enable(scrub_enable),
        .scrub_ptr_clr(scrub_ptr_clr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cfg_image(input bit [3:0] d, input bit b, input bit s, input bit e);
        return (32'(e) << 12) | (32'(s) << 11) | (32'(b) << 8) | (32'(d) << 4);
    endfunction

    function automatic int decode_op(input logic [18:0] a);
        if (a[10]) return a[7] ? 3 : 4;
        return a[9] ? 2 : 1;
    endfunction

    task automatic check_outputs();
        logic [31:0] exp_data;
        bit exp_drive;
        string dtag, vtag;
        exp_drive = (m_state == 2 || m_state == 3);
        exp_data  = (m_state == 2) ? cfg_image(m_dly, m_byp, m_sdis, m_sbe) :
                    (m_state == 3) ? {13'b0, scrub_ptr} : 32'h0;
        dtag = (m_state == 2) ? "R6" : (m_state == 3) ? "R7" : (m_state == 4) ? "R8" :
               m_chg ? "R10" : "R2";
        vtag = m_clr ? "R3" : "R4";
        chk(rd_drive == exp_drive, dtag, 32'(rd_drive), 32'(exp_drive));
        chk(rd_data == exp_data, dtag, rd_data, exp_data);
        chk({dly_code, edac_bypass, scrub_disable, single_err_mode, cfg_valid} ==
            {m_dly, m_byp, m_sdis, m_sbe, m_valid}, vtag,
            32'({dly_code, edac_bypass, scrub_disable, single_err_mode, cfg_valid}),
            32'({m_dly, m_byp, m_sdis, m_sbe, m_valid}));
        chk(scrub_ptr_clr == m_clr, "R5", 32'(scrub_ptr_clr), 32'(m_clr));
        chk(codec_enable == (m_valid && !m_byp), "R9", 32'(codec_enable), 32'(m_valid && !m_byp));
        chk(scrub_enable == (m_valid && !m_byp && !m_sdis), "R9", 32'(scrub_enable),
            32'(m_valid && !m_byp && !m_sdis));
    endtask

    task automatic model_step();
        bit key;
        int op;
        key = !ce_n && ce && oe_n && we_n && err_pin;
        op  = decode_op(addr);
        m_chg = 0;
        m_clr = 0;
        if (m_state == 0) begin
            if (key) begin
                m_state = op;
                if (op == 1) begin
                    m_dly = addr[7:4]; m_byp = addr[8]; m_sdis = addr[11]; m_sbe = addr[12];
                    m_valid = 1; m_clr = 1;
                end
            end
        end else if (!key || op != m_state) begin
            m_chg = key;
            m_state = 0;
        end
    endtask

    // one cycle: check what the last edge produced, then apply new inputs
    task automatic cyc(input bit k, input logic [18:0] a, input logic [18:0] p);
        @(negedge clk);
        check_outputs();
        ce_n = !k; ce = k; oe_n = 1'b1; we_n = 1'b1; err_pin = k;
        addr = a; scrub_ptr = p;
        model_step();
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk(rd_drive == 0 && rd_data == 0, "R1", rd_data, 32'h0);
        chk(cfg_valid == 0 && scrub_ptr_clr == 0 && dly_code == 0, "R1",
            32'({cfg_valid, scrub_ptr_clr, dly_code}), 32'h0);

        // R2: write pattern without the error pin raised
        @(negedge clk);
        ce_n = 0; ce = 1; oe_n = 1; we_n = 1; err_pin = 0; addr = 19'h01FF0;
        model_step();
        // R2: write pattern with write strobe low
        cyc(0, 19'h0, 19'h0);
        ce_n = 0; ce = 1; we_n = 0; err_pin = 1; addr = 19'h01FF0;
        model_step();
        cyc(0, 19'h0, 19'h0);
        // R3: write delay 0xA, scrub off, single mode
        cyc(1, 19'h018A0, 19'h0);
        cyc(0, 19'h0, 19'h0);
        // R6: read back
        cyc(1, 19'h00200, 19'h0);
        cyc(1, 19'h00200, 19'h0);
        cyc(0, 19'h0, 19'h0);
        // R4: held write with changing data bits
        cyc(1, 19'h00150, 19'h0);
        cyc(1, 19'h00160, 19'h0);
        cyc(1, 19'h01170, 19'h0);
        cyc(0, 19'h0, 19'h0);
        // R8: reserved
        cyc(1, 19'h00400, 19'h0);
        cyc(1, 19'h1F77F, 19'h0);
        cyc(0, 19'h0, 19'h0);
        // R7: pointer read at all ones
        cyc(1, 19'h00480, 19'h7FFFF);
        cyc(1, 19'h00480, 19'h12345);
        // R10: operation change while keyed, then to write
        cyc(1, 19'h00200, 19'h0);
        cyc(1, 19'h00200, 19'h0);
        cyc(1, 19'h000F0, 19'h0);
        cyc(1, 19'h000F0, 19'h0);
        cyc(0, 19'h0, 19'h0);

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            check_outputs();
            scrub_ptr = 19'($urandom);
            if ($urandom % 3 != 0) begin
                ce_n    = ($urandom % 10 == 0);
                ce      = ($urandom % 10 != 0);
                oe_n    = ($urandom % 10 != 0);
                we_n    = ($urandom % 10 != 0);
                err_pin = ($urandom % 5 != 0);
                addr    = 19'($urandom);
            end
            model_step();
        end
        @(negedge clk);
        check_outputs();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule